// File: doc/BRIEF.md
# Burst Column Address Generator

This block issues the column address of a synchronous DRAM burst, one address per clock. A mode write selects the burst length (2, 4 or 8 beats, or an open full-page run) and the ordering (sequential wrap or XOR interleave). A start pulse carries the first column. From the next cycle the block presents one address per cycle with a valid flag, and a done pulse marks the final beat.

A fixed-length burst ends by itself. A full-page burst runs until a stop strobe arrives. A new start on any cycle drops what is left of the current burst and begins a full new burst at the new column. Interleave ordering cannot be combined with a full-page run. That setting is executed as sequential and reported on an error flag.

Top module: `burst_colgen`

## Requirements
- R1: After reset `col_vld`, `burst_done` and `cfg_err` are low, and the mode is length code 0 with sequential ordering.
- R2: In sequential ordering, beat k presents the start column with its low B bits replaced by (start low bits + k) mod 2^B, where B is 1, 2 or 3 for length 2, 4 or 8. The upper bits do not change.
- R3: In interleave ordering, beat k presents the start column with its low B bits XOR k. For example, start low bits 5 at length 8 give 5,4,7,6,1,0,3,2.
- R4: A fixed-length burst presents exactly 2^B beats on consecutive cycles. `burst_done` is high on the last beat only, and `col_vld` is low in the cycle after it.
- R5: In full-page mode (length code 3), beat k presents (start + k) mod 2^COL_W. The run continues until stopped or restarted.
- R6: A `start` sampled on any edge makes beat 0 of a new burst, at `start_col`, appear in the next cycle. This holds even if a burst is in progress, and the new burst has the full programmed length. If `start` and `stop` are sampled together, `start` wins.
- R7: `stop` sampled during a valid beat makes `burst_done` high in that beat and `col_vld` low from the next cycle. `stop` has no effect while idle.
- R8: A mode write (`cfg_we`) takes `cfg_len` (0=2, 1=4, 2=8, 3=full page) and `cfg_ilv` (0 sequential, 1 interleave). It is ignored while `col_vld` is high.
- R9: An accepted mode write of length code 3 with `cfg_ilv`=1 runs bursts in sequential ordering and raises `cfg_err`. `cfg_err` stays high until the next accepted mode write without that combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mode write strobe |
| cfg_len | input | 2 | Burst length code |
| cfg_ilv | input | 1 | Ordering: 1 selects interleave |
| start | input | 1 | Start a new burst |
| start_col | input | COL_W | First column of the burst |
| stop | input | 1 | Terminate the current burst |
| col_out | output | COL_W | Current column address |
| col_vld | output | 1 | A beat is presented |
| burst_done | output | 1 | Final beat of the burst |
| cfg_err | output | 1 | Interleave was requested with full-page length |

## Verification
The bench starts bursts at misaligned columns. A design that carried into the upper bits, or that added where it should XOR, would present wrong columns. A full-page run is started just below the top of the page, so a counter that does not wrap at the page size shows up at once. The bench also interrupts a burst in mid-flight and counts the beats that follow. A design that resumed the old beat count would end early. A mode write during a burst would, if accepted, change the burst's length partway through. The interleave plus full-page setting would, if obeyed, produce XOR columns instead of a rising run.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
   typedef enum logic [1:0] {
      LEN_2    = 2'd0,
      LEN_4    = 2'd1,
      LEN_8    = 2'd2,
      LEN_PAGE = 2'd3
   } len_code_e;

   // number of low column bits that wrap for a fixed length
   function automatic logic [1:0] len_bits(input len_code_e c);
      case (c)
         LEN_2:   return 2'd1;
         LEN_4:   return 2'd2;
         default: return 2'd3;
      endcase
   endfunction
endpackage

// File: rtl/colgen_mode_reg.sv
module colgen_mode_reg
   import colgen_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       busy,
   input  logic       cfg_we,
   input  logic [1:0] cfg_len,
   input  logic       cfg_ilv,
   output logic [1:0] lbits,
   output logic       full,
   output logic       ilv_eff,
   output logic       err
);
   len_code_e len_q;
   logic      ilv_q;
   logic      take;

   assign take = cfg_we & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q <= LEN_2;
         ilv_q <= 1'b0;
         err   <= 1'b0;
      end else if (take) begin
         len_q <= len_code_e'(cfg_len);
         ilv_q <= cfg_ilv;
         err   <= (cfg_len == LEN_PAGE) & cfg_ilv;
      end
   end

   assign full    = (len_q == LEN_PAGE);
   assign lbits   = len_bits(len_q);
   assign ilv_eff = ilv_q & ~full;

   assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(len_q) && $stable(ilv_q)));

   assert_bad_combo_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !busy && cfg_len == 2'd3 && cfg_ilv) |=> (err && !ilv_eff));
endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr #(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [COL_W-1:0] start_col,
   input  logic             stop,
   input  logic [1:0]       lbits,
   input  logic             full,
   output logic             active,
   output logic [COL_W-1:0] base,
   output logic [COL_W-1:0] cnt,
   output logic             done
);
   logic [COL_W-1:0] last_idx;
   logic             last;

   assign last_idx = (COL_W'(1) << lbits) - COL_W'(1);
   assign last     = ~full & (cnt == last_idx);
   assign done     = active & (last | stop);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         base   <= '0;
         cnt    <= '0;
      end else if (start) begin
         active <= 1'b1;
         base   <= start_col;
         cnt    <= '0;
      end else if (active && (stop || last)) begin
         active <= 1'b0;
      end else if (active) begin
         cnt    <= cnt + COL_W'(1);
      end
   end

   assert_done_only_in_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> active);

   assert_no_early_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !last && !stop && !start) |=> active);

   assert_stop_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && stop && !start) |=> !active);
endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map #(
   parameter int COL_W = 8
) (
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] cnt,
   input  logic [1:0]       lbits,
   input  logic             full,
   input  logic             ilv,
   output logic [COL_W-1:0] col
);
   logic [COL_W-1:0] mask;
   logic [COL_W-1:0] off;

   for (genvar i = 0; i < COL_W; i++) begin : g_mask
      assign mask[i] = full | (int'(lbits) > i);
   end

   assign off = ilv ? (base ^ cnt) : (base + cnt);
   assign col = (base & ~mask) | (off & mask);
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen #(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_len,
   input  logic             cfg_ilv,
   input  logic             start,
   input  logic [COL_W-1:0] start_col,
   input  logic             stop,
   output logic [COL_W-1:0] col_out,
   output logic             col_vld,
   output logic             burst_done,
   output logic             cfg_err
);
   localparam int MIN_W = 3;

   if (COL_W < MIN_W) begin : g_bad_width
      $error("COL_W must cover an 8-beat block");
   end

   logic [1:0]       lbits;
   logic             full;
   logic             ilv_eff;
   logic             active;
   logic [COL_W-1:0] base;
   logic [COL_W-1:0] cnt;

   colgen_mode_reg u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy    (active),
      .cfg_we  (cfg_we),
      .cfg_len (cfg_len),
      .cfg_ilv (cfg_ilv),
      .lbits   (lbits),
      .full    (full),
      .ilv_eff (ilv_eff),
      .err     (cfg_err)
   );

   colgen_beat_ctr #(.COL_W(COL_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_col (start_col),
      .stop      (stop),
      .lbits     (lbits),
      .full      (full),
      .active    (active),
      .base      (base),
      .cnt       (cnt),
      .done      (burst_done)
   );

   colgen_addr_map #(.COL_W(COL_W)) u_map (
      .base  (base),
      .cnt   (cnt),
      .lbits (lbits),
      .full  (full),
      .ilv   (ilv_eff),
      .col   (col_out)
   );

   assign col_vld = active;

   assert_start_first_col_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (col_vld && col_out == $past(start_col)));

   assert_page_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (col_vld && $past(col_vld) && !$past(start) && full)
         |-> (col_out == $past(col_out) + COL_W'(1)));
endmodule

// File: tb/burst_colgen_tb.sv
module burst_colgen_tb;
   localparam int COL_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic [1:0]       cfg_len = 2'd0;
   logic             cfg_ilv = 1'b0;
   logic             start = 1'b0;
   logic [COL_W-1:0] start_col = '0;
   logic             stop = 1'b0;
   logic [COL_W-1:0] col_out;
   logic             col_vld;
   logic             burst_done;
   logic             cfg_err;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   burst_colgen #(.COL_W(COL_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len),
      .cfg_ilv(cfg_ilv), .start(start), .start_col(start_col), .stop(stop),
      .col_out(col_out), .col_vld(col_vld), .burst_done(burst_done),
      .cfg_err(cfg_err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int exp_col(input int b, input int k, input int len, input bit ilv);
      int n, lo;
      if (len == 3) return (b + k) % 256;
      n  = 2 << len;
      lo = ilv ? ((b % n) ^ k) : (((b % n) + k) % n);
      return b - (b % n) + lo;
   endfunction

   task automatic write_mode(input int len, input bit ilv);
      @(negedge clk);
      cfg_we = 1'b1; cfg_len = 2'(len); cfg_ilv = ilv;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // leaves time at negedge+1 of beat 0
   task automatic launch(input int col);
      @(negedge clk);
      start = 1'b1; start_col = COL_W'(col);
      @(negedge clk);
      start = 1'b0;
      #1;
   endtask

   task automatic next_beat();
      @(negedge clk);
      #1;
   endtask

   // run a complete fixed burst and check every beat
   task automatic run_fixed(input int col, input int len, input bit ilv, input string req);
      int nb = 2 << len;
      launch(col);
      for (int k = 0; k < nb; k++) begin
         check(col_vld === 1'b1, req, col_vld, 1);
         check(col_out === COL_W'(exp_col(col, k, len, ilv)), req, col_out, exp_col(col, k, len, ilv));
         check(burst_done === (k == nb - 1), "R4", burst_done, k == nb - 1);
         next_beat();
      end
      check(col_vld === 1'b0, "R4", col_vld, 0);
   endtask

   task automatic t_reset();
      check(col_vld === 1'b0, "R1", col_vld, 0);
      check(burst_done === 1'b0, "R1", burst_done, 0);
      check(cfg_err === 1'b0, "R1", cfg_err, 0);
      run_fixed(8'h37, 0, 1'b0, "R1");   // default: length 2, sequential
   endtask

   task automatic t_seq();
      write_mode(1, 1'b0);
      run_fixed(8'h4E, 1, 1'b0, "R2");
      write_mode(2, 1'b0);
      run_fixed(8'h2D, 2, 1'b0, "R2");
   endtask

   task automatic t_ilv();
      write_mode(2, 1'b1);
      run_fixed(8'h35, 2, 1'b1, "R3");
      write_mode(0, 1'b1);
      run_fixed(8'h11, 0, 1'b1, "R3");
      write_mode(1, 1'b1);
      run_fixed(8'hC9, 1, 1'b1, "R3");
   endtask

   task automatic t_page();
      write_mode(3, 1'b0);
      check(cfg_err === 1'b0, "R9", cfg_err, 0);
      launch(8'hFD);
      for (int k = 0; k < 6; k++) begin
         if (k == 5) begin
            @(negedge clk); stop = 1'b1; #1;
         end else if (k > 0) next_beat();
         check(col_vld === 1'b1, "R5", col_vld, 1);
         check(col_out === COL_W'(exp_col(8'hFD, k, 3, 1'b0)), "R5", col_out, exp_col(8'hFD, k, 3, 1'b0));
         check(burst_done === (k == 5), "R7", burst_done, k == 5);
      end
      @(negedge clk); stop = 1'b0; #1;
      check(col_vld === 1'b0, "R7", col_vld, 0);
      // stop while idle has no effect
      @(negedge clk); stop = 1'b1; #1;
      check(burst_done === 1'b0, "R7", burst_done, 0);
      @(negedge clk); stop = 1'b0; #1;
      check(col_vld === 1'b0, "R7", col_vld, 0);
   endtask

   task automatic t_interrupt();
      write_mode(2, 1'b0);
      launch(8'h10);
      next_beat(); next_beat();   // now at beat 2
      check(col_out === 8'h12, "R6", col_out, 8'h12);
      // restart together with stop: start must win
      @(negedge clk); start = 1'b1; start_col = 8'h63; stop = 1'b1;
      @(negedge clk); start = 1'b0; stop = 1'b0; #1;
      for (int k = 0; k < 8; k++) begin
         check(col_vld === 1'b1, "R6", col_vld, 1);
         check(col_out === COL_W'(exp_col(8'h63, k, 2, 1'b0)), "R6", col_out, exp_col(8'h63, k, 2, 1'b0));
         check(burst_done === (k == 7), "R6", burst_done, k == 7);
         next_beat();
      end
      check(col_vld === 1'b0, "R6", col_vld, 0);
   endtask

   task automatic t_busy_cfg();
      write_mode(1, 1'b0);
      launch(8'h80);
      @(negedge clk); cfg_we = 1'b1; cfg_len = 2'd2; cfg_ilv = 1'b1;
      @(negedge clk); cfg_we = 1'b0;
      #1;   // beat 2
      check(col_out === 8'h82, "R8", col_out, 8'h82);
      next_beat();
      check(burst_done === 1'b1, "R8", burst_done, 1);
      next_beat();
      check(col_vld === 1'b0, "R8", col_vld, 0);
      run_fixed(8'h85, 1, 1'b0, "R8");   // mode still length 4 sequential
   endtask

   task automatic t_bad_combo();
      write_mode(3, 1'b1);
      check(cfg_err === 1'b1, "R9", cfg_err, 1);
      launch(8'h05);
      for (int k = 0; k < 4; k++) begin
         if (k > 0) next_beat();
         check(col_out === COL_W'(8'h05 + k), "R9", col_out, 8'h05 + k);
      end
      @(negedge clk); stop = 1'b1;
      @(negedge clk); stop = 1'b0; #1;
      check(cfg_err === 1'b1, "R9", cfg_err, 1);
      write_mode(0, 1'b0);
      check(cfg_err === 1'b0, "R9", cfg_err, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1; #1;
      t_reset();
      t_seq();
      t_ilv();
      t_page();
      t_interrupt();
      t_busy_cfg();
      t_bad_combo();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule